// File: doc/BRIEF.md
# Interrupt Acknowledge and Nested Completion Unit

This block serves one processor interface of an interrupt controller. It turns an acknowledge request into a returned interrupt ID. It turns an end-of-interrupt request into the retirement of an active interrupt. An arbiter outside the block supplies the highest-pending ID. The block keeps the running ID and the running priority, and it pulses a clear of the pending bit for every interrupt it accepts.

Nesting is tracked with one link slot per interrupt ID. When an interrupt is accepted, its slot records the interrupt it preempted. Completing the running interrupt restores that link. Completing an interrupt further down the chain is handled by a multi-cycle walk, which unlinks that interrupt while the running interrupt stays in service. In legacy mode, a level-sensitive line that is still high when its interrupt completes is pulsed back to pending.

Top module: `irq_ack_nest`

## Requirements
- R1: An acknowledge whose pending ID is 1020 or greater returns that ID unchanged. It changes no state and issues no pending clear.
- R2: An acknowledge returns 1023 and leaves the running ID unchanged when the pending priority is equal to or numerically above the running priority. A lower value is a better priority.
- R3: With groups enabled, an acknowledge by a non-secure access returns 1023 when the pending interrupt's group bit is 0.
- R4: With groups enabled, an acknowledge by a secure access returns 1022 when the pending interrupt's group bit is 1 and acknowledge-control is 0. With acknowledge-control set to 1, the same acknowledge is accepted.
- R5: An accepted acknowledge takes effect on the next clock edge. At that edge `ack_valid` pulses with `ack_id` equal to the pending ID, a clear pulse carries the same ID, and the running ID becomes that ID.
- R6: After reset the running ID is 1023. The running priority is the running ID's 8-bit priority with bit 8 clear, or 0x100 when the running ID is 1023.
- R7: An end-of-interrupt is ignored when its ID is not below NUM_IDS, or when the running ID is 1023.
- R8: With groups enabled, a non-secure end-of-interrupt for a group-0 interrupt leaves the running ID and the chain unchanged.
- R9: Completing the running ID makes the ID it preempted the running ID, within one cycle.
- R10: Completing an ID other than the running one raises `busy` while the chain is walked from the running ID. The link that pointed at the completed ID takes over that ID's own link. The running ID is unchanged. The walk lasts at most NUM_IDS cycles.
- R11: In legacy mode, a valid end-of-interrupt for an interrupt that is level-configured (edge bit 0), enabled, targeted here and whose line is high pulses `set_pend_valid` with that ID. An edge-configured interrupt gets no such pulse.
- R12: While `busy` is high, acknowledge and end-of-interrupt requests are ignored. When both arrive in the same idle cycle, the acknowledge is served and the end-of-interrupt is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| groups_on | input | 1 | Interrupt grouping and security filtering in use |
| ack_ctl | input | 1 | Allows secure acknowledge of group-1 interrupts |
| legacy_mode | input | 1 | Enables level re-pend on completion |
| prio_flat | input | NUM_IDS*PRIO_W | Priority of each ID, ID n at bits n*PRIO_W upward |
| group_vec | input | NUM_IDS | Group bit for each ID (1 = group 1) |
| level_vec | input | NUM_IDS | Current line level for each ID |
| enable_vec | input | NUM_IDS | Enable bit for each ID |
| edge_vec | input | NUM_IDS | 1 = edge-configured, 0 = level-configured |
| target_vec | input | NUM_IDS | ID targets this interface |
| pend_id | input | 10 | Highest-pending ID from the arbiter |
| ack_req | input | 1 | Acknowledge request |
| ack_secure | input | 1 | Acknowledge access is secure |
| eoi_req | input | 1 | End-of-interrupt request |
| eoi_secure | input | 1 | End-of-interrupt access is secure |
| eoi_id_in | input | 10 | ID being completed |
| ack_valid | output | 1 | Acknowledge result valid (one cycle) |
| ack_id | output | 10 | Acknowledge result |
| run_id | output | 10 | Running interrupt ID, 1023 when idle |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| clr_pend_valid | output | 1 | Pulse: clear pending bit of `clr_pend_id` |
| clr_pend_id | output | 10 | ID whose pending bit is cleared |
| set_pend_valid | output | 1 | Pulse: set pending bit of `set_pend_id` |
| set_pend_id | output | 10 | ID whose pending bit is set again |
| busy | output | 1 | Chain walk in progress |

## Verification
The bound checker checks the following on every cycle:
- The idle running priority is 0x100.
- Each accepted acknowledge pulses once, with a matching clear and a matching new running ID.
- Reserved pending IDs pass through without any effect on the running ID.
- A non-secure acknowledge of a group-0 interrupt returns 1023.
- Requests during a walk produce no acknowledge.
- An end-of-interrupt received while idle changes nothing.
- No walk lasts longer than NUM_IDS cycles.

Only the directed scenarios can show that the chain unwinds in the right order. They build three-deep nesting, complete the interrupts out of order, splice an entry from the middle of the chain, and then check that the later completions skip the removed entry. The scenarios also cover the 1022 and 1023 filtering results and the legacy re-pend condition.

// File: rtl/irq_ack_nest_pkg.sv
package irq_ack_nest_pkg;
    localparam int ID_W = 10;
    typedef logic [ID_W-1:0] irq_id_t;
    localparam irq_id_t ID_NONE    = 10'd1023;
    localparam irq_id_t ID_HIDDEN  = 10'd1022;
    localparam irq_id_t ID_RSVD_LO = 10'd1020;
    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WALK = 1'b1} walk_state_e;
endpackage

// File: rtl/irq_ack_nest_prio_sel.sv
module irq_ack_nest_prio_sel
    import irq_ack_nest_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8
) (
    input  logic [NUM_IDS*PRIO_W-1:0] prio_flat,
    input  irq_id_t                   id,
    output logic [PRIO_W:0]           prio
);
    localparam int      IDX_W    = $clog2(NUM_IDS);
    localparam irq_id_t NUM_ID_V = ID_W'(NUM_IDS);

    logic [IDX_W-1:0] idx;
    assign idx = id[IDX_W-1:0];

    // an ID outside the implemented range reads as the idle priority
    always_comb begin
        if (id < NUM_ID_V) begin
            prio = {1'b0, prio_flat[idx*PRIO_W +: PRIO_W]};
        end else begin
            prio = {1'b1, {PRIO_W{1'b0}}};
        end
    end
endmodule

// File: rtl/irq_ack_nest_ack_eval.sv
module irq_ack_nest_ack_eval
    import irq_ack_nest_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8
) (
    input  irq_id_t         pend_id,
    input  logic [PRIO_W:0] pend_prio,
    input  logic [PRIO_W:0] run_prio,
    input  logic            groups_on,
    input  logic            secure,
    input  logic            pend_grp,
    input  logic            ack_ctl,
    output irq_id_t         code,
    output logic            take
);
    localparam irq_id_t NUM_ID_V = ID_W'(NUM_IDS);

    // the group filters are applied before the priority comparison
    always_comb begin
        take = 1'b0;
        code = pend_id;
        if (pend_id >= ID_RSVD_LO) begin
            code = pend_id;
        end else if (pend_id >= NUM_ID_V) begin
            code = ID_NONE;
        end else if (groups_on && !pend_grp && !secure) begin
            code = ID_NONE;
        end else if (groups_on && pend_grp && secure && !ack_ctl) begin
            code = ID_HIDDEN;
        end else if (pend_prio >= run_prio) begin
            code = ID_NONE;
        end else begin
            take = 1'b1;
        end
    end
endmodule

// File: rtl/irq_ack_nest_eoi_eval.sv
module irq_ack_nest_eoi_eval
    import irq_ack_nest_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input  irq_id_t            eoi_id,
    input  irq_id_t            run_id,
    input  logic               groups_on,
    input  logic               secure,
    input  logic               legacy_mode,
    input  logic [NUM_IDS-1:0] group_vec,
    input  logic [NUM_IDS-1:0] level_vec,
    input  logic [NUM_IDS-1:0] enable_vec,
    input  logic [NUM_IDS-1:0] edge_vec,
    input  logic [NUM_IDS-1:0] target_vec,
    output logic               act,
    output logic               repend
);
    localparam int      IDX_W    = $clog2(NUM_IDS);
    localparam irq_id_t NUM_ID_V = ID_W'(NUM_IDS);

    logic [IDX_W-1:0] idx;
    logic             live;

    assign idx  = eoi_id[IDX_W-1:0];
    assign live = (eoi_id < NUM_ID_V) && (run_id != ID_NONE);

    // a level re-pend is decided before the security filter can drop the write
    assign repend = live && legacy_mode && !edge_vec[idx] && enable_vec[idx]
                    && level_vec[idx] && target_vec[idx];
    assign act    = live && !(groups_on && !secure && !group_vec[idx]);
endmodule

// File: rtl/irq_ack_nest.sv
module irq_ack_nest
    import irq_ack_nest_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      groups_on,
    input  logic                      ack_ctl,
    input  logic                      legacy_mode,
    input  logic [NUM_IDS*PRIO_W-1:0] prio_flat,
    input  logic [NUM_IDS-1:0]        group_vec,
    input  logic [NUM_IDS-1:0]        level_vec,
    input  logic [NUM_IDS-1:0]        enable_vec,
    input  logic [NUM_IDS-1:0]        edge_vec,
    input  logic [NUM_IDS-1:0]        target_vec,
    input  logic [ID_W-1:0]           pend_id,
    input  logic                      ack_req,
    input  logic                      ack_secure,
    input  logic                      eoi_req,
    input  logic                      eoi_secure,
    input  logic [ID_W-1:0]           eoi_id_in,
    output logic                      ack_valid,
    output logic [ID_W-1:0]           ack_id,
    output logic [ID_W-1:0]           run_id,
    output logic [PRIO_W:0]           run_prio,
    output logic                      clr_pend_valid,
    output logic [ID_W-1:0]           clr_pend_id,
    output logic                      set_pend_valid,
    output logic [ID_W-1:0]           set_pend_id,
    output logic                      busy
);
    localparam int      IDX_W    = $clog2(NUM_IDS);
    localparam int      CNT_W    = $clog2(NUM_IDS + 1);
    localparam irq_id_t NUM_ID_V = ID_W'(NUM_IDS);
    localparam logic [CNT_W-1:0] STEP_MAX = CNT_W'(NUM_IDS - 1);

    typedef struct packed {
        walk_state_e                      st;
        irq_id_t                          run_id;
        logic [IDX_W-1:0]                 cursor;
        logic [IDX_W-1:0]                 target;
        logic [CNT_W-1:0]                 steps;
        logic                             ack_valid;
        irq_id_t                          ack_id;
        logic                             clr_valid;
        irq_id_t                          clr_id;
        logic                             set_valid;
        irq_id_t                          set_id;
        logic [NUM_IDS-1:0][ID_W-1:0]     link;
    } state_t;

    state_t q, d;

    logic [PRIO_W:0]  pend_prio_w, run_prio_w;
    logic [IDX_W-1:0] pend_idx, run_idx;
    logic             pend_grp;
    irq_id_t          ack_code;
    logic             ack_take, eoi_act, eoi_repend;
    irq_id_t          nxt_link;

    assign pend_idx = pend_id[IDX_W-1:0];
    assign run_idx  = q.run_id[IDX_W-1:0];
    assign pend_grp = (pend_id < NUM_ID_V) ? group_vec[pend_idx] : 1'b0;
    assign nxt_link = q.link[q.cursor];

    irq_ack_nest_prio_sel #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) u_pend_prio (
        .prio_flat (prio_flat),
        .id        (pend_id),
        .prio      (pend_prio_w)
    );

    irq_ack_nest_prio_sel #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) u_run_prio (
        .prio_flat (prio_flat),
        .id        (q.run_id),
        .prio      (run_prio_w)
    );

    irq_ack_nest_ack_eval #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) u_ack (
        .pend_id   (pend_id),
        .pend_prio (pend_prio_w),
        .run_prio  (run_prio_w),
        .groups_on (groups_on),
        .secure    (ack_secure),
        .pend_grp  (pend_grp),
        .ack_ctl   (ack_ctl),
        .code      (ack_code),
        .take      (ack_take)
    );

    irq_ack_nest_eoi_eval #(.NUM_IDS(NUM_IDS)) u_eoi (
        .eoi_id      (eoi_id_in),
        .run_id      (q.run_id),
        .groups_on   (groups_on),
        .secure      (eoi_secure),
        .legacy_mode (legacy_mode),
        .group_vec   (group_vec),
        .level_vec   (level_vec),
        .enable_vec  (enable_vec),
        .edge_vec    (edge_vec),
        .target_vec  (target_vec),
        .act         (eoi_act),
        .repend      (eoi_repend)
    );

    always_comb begin
        d           = q;
        d.ack_valid = 1'b0;
        d.clr_valid = 1'b0;
        d.set_valid = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (ack_req) begin
                    d.ack_valid = 1'b1;
                    d.ack_id    = ack_code;
                    if (ack_take) begin
                        d.link[pend_idx] = q.run_id;
                        d.clr_valid      = 1'b1;
                        d.clr_id         = pend_id;
                        d.run_id         = pend_id;
                    end
                end else if (eoi_req) begin
                    if (eoi_repend) begin
                        d.set_valid = 1'b1;
                        d.set_id    = eoi_id_in;
                    end
                    if (eoi_act) begin
                        if (eoi_id_in == q.run_id) begin
                            d.run_id = q.link[run_idx];
                        end else begin
                            d.st     = ST_WALK;
                            d.cursor = run_idx;
                            d.target = eoi_id_in[IDX_W-1:0];
                            d.steps  = '0;
                        end
                    end
                end
            end
            default: begin
                // follow one link per cycle until the completed ID is found
                d.steps = q.steps + 1'b1;
                if (nxt_link == ID_W'(q.target)) begin
                    d.link[q.cursor] = q.link[q.target];
                    d.st             = ST_IDLE;
                end else if (nxt_link == ID_NONE || q.steps == STEP_MAX) begin
                    d.st = ST_IDLE;
                end else begin
                    d.cursor = nxt_link[IDX_W-1:0];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.run_id    <= ID_NONE;
            q.cursor    <= '0;
            q.target    <= '0;
            q.steps     <= '0;
            q.ack_valid <= 1'b0;
            q.ack_id    <= ID_NONE;
            q.clr_valid <= 1'b0;
            q.clr_id    <= ID_NONE;
            q.set_valid <= 1'b0;
            q.set_id    <= ID_NONE;
            q.link      <= {NUM_IDS{ID_NONE}};
        end else begin
            q <= d;
        end
    end

    assign ack_valid      = q.ack_valid;
    assign ack_id         = q.ack_id;
    assign run_id         = q.run_id;
    assign run_prio       = run_prio_w;
    assign clr_pend_valid = q.clr_valid;
    assign clr_pend_id    = q.clr_id;
    assign set_pend_valid = q.set_valid;
    assign set_pend_id    = q.set_id;
    assign busy           = (q.st == ST_WALK);
endmodule

// File: rtl/irq_ack_nest_chk.sv
module irq_ack_nest_chk #(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               groups_on,
    input logic [NUM_IDS-1:0] group_vec,
    input logic [9:0]         pend_id,
    input logic               ack_req,
    input logic               ack_secure,
    input logic               eoi_req,
    input logic               ack_valid,
    input logic [9:0]         ack_id,
    input logic [9:0]         run_id,
    input logic [PRIO_W:0]    run_prio,
    input logic               clr_pend_valid,
    input logic [9:0]         clr_pend_id,
    input logic               busy
);
    localparam int IDX_W = $clog2(NUM_IDS);

    logic [15:0] busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_run <= '0;
        else if (busy) busy_run <= busy_run + 16'd1;
        else busy_run <= '0;
    end

    AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == 10'd1023) |-> (run_prio == {1'b1, {PRIO_W{1'b0}}})); // R6

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !busy) |=> ack_valid); // R5

    AST_ACK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id < 10'(NUM_IDS)) |-> (run_id == ack_id && clr_pend_valid)); // R5

    AST_CLR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend_valid |-> (ack_valid && clr_pend_id == ack_id)); // R5

    AST_RSVD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !busy && pend_id >= 10'd1020) |=>
        (ack_id == $past(pend_id) && $stable(run_id) && !clr_pend_valid)); // R1

    AST_NS_GRP0: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && !busy && groups_on && !ack_secure && pend_id < 10'(NUM_IDS)
         && !group_vec[pend_id[IDX_W-1:0]]) |=> (ack_id == 10'd1023)); // R3

    AST_EOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !ack_req && !busy && run_id == 10'd1023) |=>
        (run_id == 10'd1023 && !busy)); // R7

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ack_valid); // R12

    AST_WALK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= 16'(NUM_IDS)); // R10
endmodule

bind irq_ack_nest irq_ack_nest_chk #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .groups_on      (groups_on),
    .group_vec      (group_vec),
    .pend_id        (pend_id),
    .ack_req        (ack_req),
    .ack_secure     (ack_secure),
    .eoi_req        (eoi_req),
    .ack_valid      (ack_valid),
    .ack_id         (ack_id),
    .run_id         (run_id),
    .run_prio       (run_prio),
    .clr_pend_valid (clr_pend_valid),
    .clr_pend_id    (clr_pend_id),
    .busy           (busy)
);

// File: tb/test_irq_ack_nest.sv
`timescale 1ns/1ps
module test_irq_ack_nest;
    localparam int N  = 64;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic groups_on = 1'b0, ack_ctl = 1'b0, legacy_mode = 1'b0;
    logic [PW-1:0] prio_tab [N];
    logic [N*PW-1:0] prio_flat;
    logic [N-1:0] group_vec = '0, level_vec = '0, enable_vec = '0, edge_vec = '0, target_vec = '0;
    logic [9:0] pend_id = 10'd1023;
    logic ack_req = 1'b0, ack_secure = 1'b1, eoi_req = 1'b0, eoi_secure = 1'b1;
    logic [9:0] eoi_id_in = '0;
    logic ack_valid, clr_pend_valid, set_pend_valid, busy;
    logic [9:0] ack_id, run_id, clr_pend_id, set_pend_id;
    logic [PW:0] run_prio;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int r_ack_valid, r_ack_id, r_clr_valid, r_clr_id, r_set_valid, r_set_id, walk_cycles;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = prio_tab[i];
    end

    irq_ack_nest #(.NUM_IDS(N), .PRIO_W(PW)) i_irq_ack_nest (
        .clk(clk), .rst_n(rst_n), .groups_on(groups_on), .ack_ctl(ack_ctl),
        .legacy_mode(legacy_mode), .prio_flat(prio_flat), .group_vec(group_vec),
        .level_vec(level_vec), .enable_vec(enable_vec), .edge_vec(edge_vec),
        .target_vec(target_vec), .pend_id(pend_id), .ack_req(ack_req),
        .ack_secure(ack_secure), .eoi_req(eoi_req), .eoi_secure(eoi_secure),
        .eoi_id_in(eoi_id_in), .ack_valid(ack_valid), .ack_id(ack_id),
        .run_id(run_id), .run_prio(run_prio), .clr_pend_valid(clr_pend_valid),
        .clr_pend_id(clr_pend_id), .set_pend_valid(set_pend_valid),
        .set_pend_id(set_pend_id), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_ack(input int id, input logic sec);
        @(negedge clk);
        pend_id = 10'(id); ack_secure = sec; ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        r_ack_valid = int'(ack_valid); r_ack_id = int'(ack_id);
        r_clr_valid = int'(clr_pend_valid); r_clr_id = int'(clr_pend_id);
    endtask

    task automatic do_eoi(input int id, input logic sec);
        @(negedge clk);
        eoi_id_in = 10'(id); eoi_secure = sec; eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
        r_set_valid = int'(set_pend_valid); r_set_id = int'(set_pend_id);
        walk_cycles = 0;
        while (busy && walk_cycles < 200) begin
            @(negedge clk);
            walk_cycles++;
        end
    endtask

    task automatic t_reset();
        check("R6 reset run_id", int'(run_id), 1023);
        check("R6 reset run_prio", int'(run_prio), 256);
        check("R12 reset busy", int'(busy), 0);
        check("R5 reset ack_valid", int'(ack_valid), 0);
    endtask

    task automatic t_reserved();
        do_ack(1021, 1'b1);
        check("R1 reserved id returned", r_ack_id, 1021);
        check("R1 reserved no clear", r_clr_valid, 0);
        check("R1 reserved run unchanged", int'(run_id), 1023);
    endtask

    task automatic t_nest();
        prio_tab[5] = 8'h80; prio_tab[6] = 8'h40; prio_tab[7] = 8'h20;
        prio_tab[8] = 8'h20; prio_tab[9] = 8'h90;
        do_ack(5, 1'b1);
        check("R5 ack5 id", r_ack_id, 5);
        check("R5 ack5 clear id", r_clr_id, 5);
        check("R5 ack5 run", int'(run_id), 5);
        check("R6 prio of 5", int'(run_prio), 'h80);
        do_ack(6, 1'b1);
        check("R5 ack6 run", int'(run_id), 6);
        do_ack(7, 1'b1);
        check("R5 ack7 run", int'(run_id), 7);
        check("R6 prio of 7", int'(run_prio), 'h20);
        do_ack(8, 1'b1);
        check("R2 equal prio blocked", r_ack_id, 1023);
        check("R2 equal prio no clear", r_clr_valid, 0);
        do_ack(9, 1'b1);
        check("R2 worse prio blocked", r_ack_id, 1023);
        check("R2 run kept", int'(run_id), 7);
        do_eoi(6, 1'b1);
        check("R10 splice walk length", walk_cycles, 1);
        check("R10 run unchanged after splice", int'(run_id), 7);
        do_eoi(7, 1'b1);
        check("R9 complete 7 returns to 5", int'(run_id), 5);
        check("R6 prio back to 5", int'(run_prio), 'h80);
        do_eoi(5, 1'b1);
        check("R9 complete 5 idle", int'(run_id), 1023);
    endtask

    task automatic t_groups();
        groups_on = 1'b1;
        prio_tab[10] = 8'h30; prio_tab[11] = 8'h60;
        group_vec[10] = 1'b0; group_vec[11] = 1'b1;
        do_ack(10, 1'b0);
        check("R3 nonsecure group0 ack", r_ack_id, 1023);
        ack_ctl = 1'b0;
        do_ack(11, 1'b1);
        check("R4 secure group1 ackctl clear", r_ack_id, 1022);
        check("R4 hidden run unchanged", int'(run_id), 1023);
        ack_ctl = 1'b1;
        do_ack(11, 1'b1);
        check("R4 secure group1 ackctl set", r_ack_id, 11);
        do_ack(10, 1'b1);
        check("R3 secure group0 accepted", int'(run_id), 10);
        do_eoi(10, 1'b0);
        check("R8 nonsecure eoi group0 ignored", int'(run_id), 10);
        do_eoi(10, 1'b1);
        check("R8 secure eoi group0 done", int'(run_id), 11);
        do_eoi(11, 1'b0);
        check("R8 nonsecure eoi group1 done", int'(run_id), 1023);
        groups_on = 1'b0; ack_ctl = 1'b0;
    endtask

    task automatic t_eoi_filter();
        do_eoi(5, 1'b1);
        check("R7 eoi while idle ignored", int'(run_id), 1023);
        check("R7 eoi idle no walk", walk_cycles, 0);
        do_ack(5, 1'b1);
        do_eoi(100, 1'b1);
        check("R7 eoi unimplemented id ignored", int'(run_id), 5);
        do_eoi(5, 1'b1);
        check("R7 valid eoi completes", int'(run_id), 1023);
    endtask

    task automatic t_legacy();
        legacy_mode = 1'b1;
        prio_tab[20] = 8'h50;
        level_vec[20] = 1'b1; enable_vec[20] = 1'b1; target_vec[20] = 1'b1; edge_vec[20] = 1'b0;
        do_ack(20, 1'b1);
        do_eoi(20, 1'b1);
        check("R11 level re-pend pulse", r_set_valid, 1);
        check("R11 level re-pend id", r_set_id, 20);
        check("R11 completed anyway", int'(run_id), 1023);
        edge_vec[20] = 1'b1;
        do_ack(20, 1'b1);
        do_eoi(20, 1'b1);
        check("R11 edge no re-pend", r_set_valid, 0);
        edge_vec[20] = 1'b0; level_vec[20] = 1'b0;
        do_ack(20, 1'b1);
        do_eoi(20, 1'b1);
        check("R11 low line no re-pend", r_set_valid, 0);
        legacy_mode = 1'b0;
    endtask

    task automatic t_busy();
        prio_tab[2] = 8'h10;
        do_ack(5, 1'b1); do_ack(6, 1'b1); do_ack(7, 1'b1);
        @(negedge clk);
        eoi_id_in = 10'd5; eoi_secure = 1'b1; eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
        check("R10 busy during walk", int'(busy), 1);
        pend_id = 10'd2; ack_secure = 1'b1; ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        check("R12 ack during busy dropped", int'(ack_valid), 0);
        walk_cycles = 0;
        while (busy && walk_cycles < 200) begin
            @(negedge clk);
            walk_cycles++;
        end
        check("R12 run kept after busy ack", int'(run_id), 7);
        do_eoi(7, 1'b1);
        check("R10 unwind to 6", int'(run_id), 6);
        do_eoi(6, 1'b1);
        check("R10 5 was spliced out", int'(run_id), 1023);
        do_ack(6, 1'b1);
        @(negedge clk);
        pend_id = 10'd7; ack_req = 1'b1;
        eoi_id_in = 10'd6; eoi_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0; eoi_req = 1'b0;
        check("R12 simultaneous ack served", int'(ack_id), 7);
        do_eoi(7, 1'b1);
        check("R12 simultaneous eoi dropped", int'(run_id), 6);
        do_eoi(6, 1'b1);
        check("R12 chain empty", int'(run_id), 1023);
    endtask

    initial begin
        for (int i = 0; i < N; i++) prio_tab[i] = 8'hF0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_nest();
        t_groups();
        t_eoi_filter();
        t_legacy();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule